// File: doc/BRIEF.md
# Configurable Pin I/O Cell

This block sits between the core logic and a group of package pins. Each bit lane has an output side and an input side. On the output side the core value can be inverted and then sent to the pin either combinationally or through a storage flop. That flop has its own clock and clock enable. A static configuration selects one of three driver styles: always driving, three-state with a selectable enable source, or drive-low-only open collector. On the input side the pin value reaches the core either directly or through a second flop. That flop runs on a separate input clock with its own enable and serves as a synchronizer.

The pin is modelled as a driven value and a per-bit enable, with no bidirectional net. The pin level seen from outside arrives on a separate input. Every lane in the group shares the same configuration. The lane count is a parameter.

Top module: `iocell_pad`

## Requirements
- R1: After the active-low reset `rst_n`, both flops hold zero. With registered output, no inversion and the always-driving style, `pad_o` is 0. With a registered input, `core_din` is 0.
- R2: When `cfg_invert` is 1, the core data is inverted before the choice between the direct and registered paths. A value captured by the output flop therefore keeps its inversion if `cfg_invert` changes later.
- R3: When `cfg_out_reg` is 1, the output data is the value captured at the last rising `out_clk` edge on which `out_ce` was 1. An edge with `out_ce` at 0 leaves it unchanged.
- R4: When `cfg_out_reg` is 0, the output data follows the (optionally inverted) `core_dout` combinationally.
- R5: `cfg_drive` selects the driver style:
  - 2'b00, always driving: `pad_oe` is all ones and `pad_o` equals the data.
  - 2'b01 and 2'b11, three-state: `pad_oe` comes from the enable source. `pad_o` equals the data where the enable is 1 and 0 elsewhere.
  - 2'b10, open collector: `pad_o` is 0 and `pad_oe` is the bitwise inverse of the data.
  - In no style is a `pad_o` bit 1 while its `pad_oe` bit is 0.
- R6: In the three-state style, `cfg_oe_src` picks the enable: 2'b00 uses `core_oe` per bit, 2'b01 is all on, and 2'b10 and 2'b11 are all off.
- R7: When `cfg_in_reg` is 0, `core_din` follows `pad_i` combinationally.
- R8: When `cfg_in_reg` is 1, `core_din` is the value of `pad_i` captured at the last rising `in_clk` edge on which `in_ce` was 1. An edge with `in_ce` at 0 leaves it unchanged.
- R9: The two flops are independent. An `in_clk` edge never changes the output flop, an `out_clk` edge never changes the input flop, and edges of both clocks at the same moment update both flops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset of both flops |
| out_clk | input | 1 | Clock of the output flop |
| out_ce | input | 1 | Clock enable of the output flop |
| in_clk | input | 1 | Clock of the input flop |
| in_ce | input | 1 | Clock enable of the input flop |
| cfg_drive | input | 2 | Driver style select |
| cfg_oe_src | input | 2 | Enable source select for three-state style |
| cfg_invert | input | 1 | Invert output data |
| cfg_out_reg | input | 1 | Route output through its flop |
| cfg_in_reg | input | 1 | Route input through its flop |
| core_dout | input | WIDTH | Data from the core toward the pins |
| core_oe | input | WIDTH | Per-bit enable from the core |
| pad_o | output | WIDTH | Value driven toward the pins |
| pad_oe | output | WIDTH | Per-bit driver enable |
| pad_i | input | WIDTH | Level present on the pins |
| core_din | output | WIDTH | Pin data delivered to the core |

## Verification
The output flop and the input flop can both take an edge in the same instant. The bench provokes this by raising `out_clk` and `in_clk` together with both enables set and different data on each side. It then checks that each flop took its own side's value. A second case raises only `in_clk` while `out_ce` is 1 and checks that the output data stays where it was.

// File: rtl/iocell_pkg.sv
package iocell_pkg;

    typedef enum logic [1:0] {
        DRV_PUSH    = 2'b00,
        DRV_TRI     = 2'b01,
        DRV_OPEN    = 2'b10,
        DRV_TRI_ALT = 2'b11
    } drive_e;

    typedef enum logic [1:0] {
        OES_CORE    = 2'b00,
        OES_ON      = 2'b01,
        OES_OFF     = 2'b10,
        OES_OFF_ALT = 2'b11
    } oe_src_e;

endpackage

// File: rtl/iocell_opath.sv
module iocell_opath #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic             invert,
    input  logic             use_reg,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dsel
);

    typedef struct packed {
        logic [WIDTH-1:0] data;
    } ost_t;

    ost_t             st_d, st_q;
    logic [WIDTH-1:0] pre;

    always_comb begin
        pre       = din ^ {WIDTH{invert}};
        st_d      = st_q;
        if (ce) begin
            st_d.data = pre;
        end
        dsel      = use_reg ? st_q.data : pre;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(st_q.data)); // R3

    AST_OUT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        ce |=> (st_q.data == $past(din ^ {WIDTH{invert}}))); // R3

endmodule

// File: rtl/iocell_ipath.sv
module iocell_ipath #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic             use_reg,
    input  logic [WIDTH-1:0] pin,
    output logic [WIDTH-1:0] dout
);

    typedef struct packed {
        logic [WIDTH-1:0] sync;
    } ist_t;

    ist_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ce) begin
            st_d.sync = pin;
        end
        dout = use_reg ? st_q.sync : pin;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(st_q.sync)); // R8

    AST_IN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        ce |=> (st_q.sync == $past(pin))); // R8

endmodule

// File: rtl/iocell_drv.sv
module iocell_drv
    import iocell_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  drive_e           mode,
    input  oe_src_e          oe_src,
    input  logic [WIDTH-1:0] core_oe,
    input  logic [WIDTH-1:0] data,
    output logic [WIDTH-1:0] pad_o,
    output logic [WIDTH-1:0] pad_oe
);

    logic [WIDTH-1:0] en_sel;

    always_comb begin
        case (oe_src)
            OES_CORE: en_sel = core_oe;
            OES_ON:   en_sel = '1;
            default:  en_sel = '0;
        endcase
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_comb begin
            case (mode)
                DRV_PUSH: begin
                    pad_oe[i] = 1'b1;
                    pad_o[i]  = data[i];
                end
                DRV_OPEN: begin
                    pad_oe[i] = ~data[i];
                    pad_o[i]  = 1'b0;
                end
                default: begin
                    pad_oe[i] = en_sel[i];
                    pad_o[i]  = en_sel[i] & data[i];
                end
            endcase
        end
    end

endmodule

// File: rtl/iocell_pad.sv
module iocell_pad
    import iocell_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             rst_n,
    input  logic             out_clk,
    input  logic             out_ce,
    input  logic             in_clk,
    input  logic             in_ce,
    input  logic [1:0]       cfg_drive,
    input  logic [1:0]       cfg_oe_src,
    input  logic             cfg_invert,
    input  logic             cfg_out_reg,
    input  logic             cfg_in_reg,
    input  logic [WIDTH-1:0] core_dout,
    input  logic [WIDTH-1:0] core_oe,
    output logic [WIDTH-1:0] pad_o,
    output logic [WIDTH-1:0] pad_oe,
    input  logic [WIDTH-1:0] pad_i,
    output logic [WIDTH-1:0] core_din
);

    logic [WIDTH-1:0] out_data;
    drive_e           mode;
    oe_src_e          oe_src;

    assign mode   = drive_e'(cfg_drive);
    assign oe_src = oe_src_e'(cfg_oe_src);

    iocell_opath #(.WIDTH(WIDTH)) u_opath (
        .clk     (out_clk),
        .rst_n   (rst_n),
        .ce      (out_ce),
        .invert  (cfg_invert),
        .use_reg (cfg_out_reg),
        .din     (core_dout),
        .dsel    (out_data)
    );

    iocell_drv #(.WIDTH(WIDTH)) u_drv (
        .mode    (mode),
        .oe_src  (oe_src),
        .core_oe (core_oe),
        .data    (out_data),
        .pad_o   (pad_o),
        .pad_oe  (pad_oe)
    );

    iocell_ipath #(.WIDTH(WIDTH)) u_ipath (
        .clk     (in_clk),
        .rst_n   (rst_n),
        .ce      (in_ce),
        .use_reg (cfg_in_reg),
        .pin     (pad_i),
        .dout    (core_din)
    );

    AST_PUSH_DRIVES: assert property (@(posedge out_clk) disable iff (!rst_n)
        (cfg_drive == 2'b00) |-> (&pad_oe)); // R5

    AST_OC_NEVER_HIGH: assert property (@(posedge out_clk) disable iff (!rst_n)
        (cfg_drive == 2'b10) |-> (pad_o == '0)); // R5

    AST_NO_HIGH_UNDRIVEN: assert property (@(posedge out_clk) disable iff (!rst_n)
        ((pad_o & ~pad_oe) == '0)); // R5

    AST_OE_FORCED_OFF: assert property (@(posedge out_clk) disable iff (!rst_n)
        (cfg_drive[0] && cfg_oe_src[1]) |-> (pad_oe == '0)); // R6

endmodule

// File: tb/iocell_pad_tb.sv
module iocell_pad_tb;

    localparam int  W          = 4;
    localparam time CLK_PERIOD = 10;

    logic         rst_n, out_clk, out_ce, in_clk, in_ce;
    logic [1:0]   cfg_drive, cfg_oe_src;
    logic         cfg_invert, cfg_out_reg, cfg_in_reg;
    logic [W-1:0] core_dout, core_oe, pad_i;
    logic [W-1:0] pad_o, pad_oe, core_din;

    int n_chk  = 0;
    int n_fail = 0;

    iocell_pad #(.WIDTH(W)) u_dut (
        .rst_n(rst_n), .out_clk(out_clk), .out_ce(out_ce),
        .in_clk(in_clk), .in_ce(in_ce),
        .cfg_drive(cfg_drive), .cfg_oe_src(cfg_oe_src),
        .cfg_invert(cfg_invert), .cfg_out_reg(cfg_out_reg),
        .cfg_in_reg(cfg_in_reg),
        .core_dout(core_dout), .core_oe(core_oe),
        .pad_o(pad_o), .pad_oe(pad_oe),
        .pad_i(pad_i), .core_din(core_din)
    );

    task automatic chk(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic pulse(input logic do_out, input logic do_in);
        #(CLK_PERIOD/2);
        if (do_out) out_clk = 1'b1;
        if (do_in)  in_clk  = 1'b1;
        #(CLK_PERIOD/2);
        out_clk = 1'b0;
        in_clk  = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        cfg_drive = 2'b00; cfg_out_reg = 1'b1; cfg_invert = 1'b0;
        cfg_in_reg = 1'b1; core_dout = 4'b1111; pad_i = 4'b1111;
        settle();
        chk("R1", "pad_o after reset", pad_o, 4'b0000);
        chk("R1", "pad_oe after reset", pad_oe, 4'b1111);
        chk("R1", "core_din after reset", core_din, 4'b0000);
    endtask

    task automatic t_direct_out();
        cfg_drive = 2'b00; cfg_out_reg = 1'b0; cfg_invert = 1'b0;
        core_dout = 4'b1011; settle();
        chk("R4", "direct pad_o", pad_o, 4'b1011);
        core_dout = 4'b0110; settle();
        chk("R4", "direct follows", pad_o, 4'b0110);
        cfg_invert = 1'b1; settle();
        chk("R2", "direct inverted", pad_o, 4'b1001);
        cfg_invert = 1'b0;
    endtask

    task automatic t_reg_out();
        cfg_drive = 2'b00; cfg_out_reg = 1'b1; cfg_invert = 1'b0;
        out_ce = 1'b1; core_dout = 4'b1100; settle();
        chk("R3", "before edge", pad_o, 4'b0000);
        pulse(1'b1, 1'b0);
        chk("R3", "captured with ce", pad_o, 4'b1100);
        out_ce = 1'b0; core_dout = 4'b0011;
        pulse(1'b1, 1'b0);
        chk("R3", "held without ce", pad_o, 4'b1100);
        out_ce = 1'b1; cfg_invert = 1'b1; core_dout = 4'b0101;
        pulse(1'b1, 1'b0);
        chk("R2", "registered inverted", pad_o, 4'b1010);
        out_ce = 1'b0; cfg_invert = 1'b0; settle();
        chk("R2", "stored inversion kept", pad_o, 4'b1010);
    endtask

    task automatic t_modes();
        cfg_out_reg = 1'b0; cfg_invert = 1'b0;
        core_dout = 4'b1010; core_oe = 4'b0110;
        cfg_drive = 2'b01; cfg_oe_src = 2'b00; settle();
        chk("R6", "tri core oe", pad_oe, 4'b0110);
        chk("R5", "tri masked data", pad_o, 4'b0010);
        cfg_oe_src = 2'b01; settle();
        chk("R6", "tri forced on", pad_oe, 4'b1111);
        chk("R5", "tri on data", pad_o, 4'b1010);
        cfg_oe_src = 2'b10; settle();
        chk("R6", "tri forced off", pad_oe, 4'b0000);
        chk("R5", "tri off data", pad_o, 4'b0000);
        cfg_oe_src = 2'b11; cfg_drive = 2'b11; settle();
        chk("R6", "alt codes off", pad_oe, 4'b0000);
        cfg_oe_src = 2'b00; settle();
        chk("R5", "alt tri core oe", pad_oe, 4'b0110);
        cfg_drive = 2'b10; settle();
        chk("R5", "open collector oe", pad_oe, 4'b0101);
        chk("R5", "open collector low", pad_o, 4'b0000);
        cfg_invert = 1'b1; settle();
        chk("R5", "open collector inverted oe", pad_oe, 4'b1010);
        cfg_drive = 2'b00; cfg_oe_src = 2'b10; cfg_invert = 1'b0; settle();
        chk("R5", "push ignores oe source", pad_oe, 4'b1111);
    endtask

    task automatic t_input();
        cfg_in_reg = 1'b0; pad_i = 4'b1001; settle();
        chk("R7", "direct input", core_din, 4'b1001);
        pad_i = 4'b0111; settle();
        chk("R7", "direct follows", core_din, 4'b0111);
        cfg_in_reg = 1'b1; in_ce = 1'b1; pad_i = 4'b1110; settle();
        chk("R8", "before edge", core_din, 4'b0000);
        pulse(1'b0, 1'b1);
        chk("R8", "captured with ce", core_din, 4'b1110);
        in_ce = 1'b0; pad_i = 4'b0001;
        pulse(1'b0, 1'b1);
        chk("R8", "held without ce", core_din, 4'b1110);
    endtask

    task automatic t_coincide();
        cfg_drive = 2'b00; cfg_out_reg = 1'b1; cfg_in_reg = 1'b1; cfg_invert = 1'b0;
        out_ce = 1'b1; in_ce = 1'b1; core_dout = 4'b0110; pad_i = 4'b1001;
        pulse(1'b1, 1'b1);
        chk("R9", "both edges out", pad_o, 4'b0110);
        chk("R9", "both edges in", core_din, 4'b1001);
        core_dout = 4'b1111; pad_i = 4'b0100;
        pulse(1'b0, 1'b1);
        chk("R9", "in edge leaves out flop", pad_o, 4'b0110);
        chk("R9", "in edge captures", core_din, 4'b0100);
        pad_i = 4'b0010;
        pulse(1'b1, 1'b0);
        chk("R9", "out edge leaves in flop", core_din, 4'b0100);
        chk("R9", "out edge captures", pad_o, 4'b1111);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; out_clk = 1'b0; in_clk = 1'b0; out_ce = 1'b0; in_ce = 1'b0;
        cfg_drive = 2'b00; cfg_oe_src = 2'b00; cfg_invert = 1'b0;
        cfg_out_reg = 1'b0; cfg_in_reg = 1'b0;
        core_dout = '0; core_oe = '0; pad_i = '0;
        #(CLK_PERIOD);
        t_reset();
        rst_n = 1'b1;
        #(CLK_PERIOD);
        t_reset();
        t_direct_out();
        t_reg_out();
        t_modes();
        t_input();
        t_coincide();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule